// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects two interrupt conditions, a clock-synthesizer unlock flag and a converter over-range flag, into one read-only status register. Each bit is sticky: once its condition has been seen on any clock edge, it stays set until software reads the register. That read returns the accumulated value and clears every bit at once. A mask register decides which sources may record and report. Bits whose source is masked always read as zero.

A 2-bit pin-mode field sets how the pending interrupt appears on the single output pin. The pin can be active-high, active-low, or open-drain active-low. In the open-drain mode the output-enable is asserted only while the pin is pulled low. All three registers sit on a simple strobe bus. Read data is registered, so it appears on the cycle after the read strobe and then holds until the next read.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status register reads 0x00, the mask register reads 0x82 (both sources enabled), the mode register reads 0x00, `irq_pin` is 0 and `irq_oe` is 1.
- R2: A pulse on `evt_unlock` sets status bit 7 and a pulse on `evt_ovfl` sets status bit 1. Each bit stays set until a status read. Status bits 6..2 and bit 0 always read 0.
- R3: A read strobe at address 0 (status) returns the status value on `bus_rdata` one cycle later and clears every status bit in the same clock edge.
- R4: An event in the same cycle as a status read wins over the clear. The read returns the value from before the clear, and the event's bit is set afterwards.
- R5: While a source's mask bit is 0, its status bit reads 0, its events are not recorded, and it does not make the interrupt pending. Clearing a mask bit also discards that source's stored status.
- R6: The mask register at address 1 can be read and written. Only bit 7 (unlock) and bit 1 (overflow) are writable; the other bits read 0.
- R7: With pin mode 00, `irq_pin` is 1 exactly while any unmasked status bit is set, and `irq_oe` is 1.
- R8: With pin mode 01, `irq_pin` is 0 exactly while an interrupt is pending, and `irq_oe` is 1.
- R9: With pin mode 10 (open-drain), `irq_pin` is always 0 and `irq_oe` is 1 exactly while an interrupt is pending.
- R10: Reserved pin mode 11 behaves like mode 00.
- R11: Writes to the status address have no effect on the status bits.
- R12: An event input held high sets its bit again on every clock edge, so the bit is still set after a read while the condition lasts.
- R13: The mode register at address 2 holds the pin mode in bits 1..0. Address 3 reads 0. `bus_rdata` keeps its last value while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (0 status, 1 mask, 2 mode) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_unlock | input | 1 | Unlock condition, sampled each clock |
| evt_ovfl | input | 1 | Over-range condition, sampled each clock |
| irq_pin | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Pin output-enable (released in open-drain idle) |

## Verification
An event or a register write takes effect at the first rising edge that samples it. The pin follows the status and mode registers through logic only, so pin level and enable are checked at the falling edge right after that rising edge. Read data has one register stage. The driver task therefore pushes the expected word into the scoreboard queue when it raises the strobe, and the monitor pops and compares at the falling edge after the rising edge that captured the strobe. All stimulus changes on falling edges, so no sample races an update.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

   typedef enum logic [1:0] {
      PIN_ACT_HIGH = 2'b00,
      PIN_ACT_LOW  = 2'b01,
      PIN_OPEN_DRN = 2'b10,
      PIN_RSVD     = 2'b11
   } pin_mode_e;

   localparam int unsigned MODE_W = 2;

   function automatic pin_mode_e norm_mode(input logic [MODE_W-1:0] raw);
      pin_mode_e m;
      case (raw)
         2'b01:   m = PIN_ACT_LOW;
         2'b10:   m = PIN_OPEN_DRN;
         default: m = PIN_ACT_HIGH;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int unsigned          DATA_W  = 8,
   parameter logic [DATA_W-1:0]    SRC_MAP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_vec,
   input  logic [DATA_W-1:0] mask_q,
   input  logic              rd_clr,
   output logic [DATA_W-1:0] stat_q
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (SRC_MAP[b]) begin : g_src
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (!mask_q[b]) begin
               bit_q <= 1'b0;
            end else if (evt_vec[b]) begin
               bit_q <= 1'b1;
            end else if (rd_clr) begin
               bit_q <= 1'b0;
            end
         end
         assign stat_q[b] = bit_q;
      end else begin : g_rsvd
         assign stat_q[b] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
   import irq_status_pkg::*;
#(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       ADDR_W    = 2,
   parameter int unsigned       STAT_ADDR = 0,
   parameter int unsigned       MASK_ADDR = 1,
   parameter int unsigned       MODE_ADDR = 2,
   parameter bit                REG_RDATA = 1'b1,
   parameter logic [DATA_W-1:0] SRC_MAP   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] mask_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              stat_rd
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);

   logic              hit_stat, hit_mask, hit_mode;
   logic [DATA_W-1:0] rd_mux;

   assign hit_stat = (bus_addr == A_STAT);
   assign hit_mask = (bus_addr == A_MASK);
   assign hit_mode = (bus_addr == A_MODE);
   assign stat_rd  = bus_rd && hit_stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= SRC_MAP;
      end else if (bus_wr && hit_mask) begin
         mask_q <= bus_wdata & SRC_MAP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (bus_wr && hit_mode) begin
         mode_q <= bus_wdata[MODE_W-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit_stat) begin
         rd_mux = stat_q & mask_q;
      end else if (hit_mask) begin
         rd_mux = mask_q;
      end else if (hit_mode) begin
         rd_mux[MODE_W-1:0] = mode_q;
      end
   end

   if (REG_RDATA) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q <= '0;
         end else if (bus_rd) begin
            rdata_q <= rd_mux;
         end
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
   import irq_status_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] stat_q,
   input  logic [DATA_W-1:0] mask_q,
   input  logic [MODE_W-1:0] mode_q,
   output logic              irq_pin,
   output logic              irq_oe
);

   logic      pending;
   pin_mode_e mode;

   assign pending = |(stat_q & mask_q);
   assign mode    = norm_mode(mode_q);

   always_comb begin
      irq_pin = pending;
      irq_oe  = 1'b1;
      case (mode)
         PIN_ACT_LOW: begin
            irq_pin = !pending;
         end
         PIN_OPEN_DRN: begin
            irq_pin = 1'b0;
            irq_oe  = pending;
         end
         default: begin
            irq_pin = pending;
         end
      endcase
   end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_status_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned STAT_ADDR  = 0,
   parameter int unsigned MASK_ADDR  = 1,
   parameter int unsigned MODE_ADDR  = 2,
   parameter int unsigned UNLOCK_BIT = 7,
   parameter int unsigned OVFL_BIT   = 1,
   parameter bit          REG_RDATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              evt_unlock,
   input  logic              evt_ovfl,
   output logic              irq_pin,
   output logic              irq_oe
);

   localparam logic [DATA_W-1:0] SRC_MAP =
      (DATA_W'(1) << UNLOCK_BIT) | (DATA_W'(1) << OVFL_BIT);

   if (DATA_W < 8) begin : g_chk_w
      $error("irq_status_ctrl: DATA_W must be at least 8");
   end
   if (UNLOCK_BIT >= DATA_W || OVFL_BIT >= DATA_W || UNLOCK_BIT == OVFL_BIT) begin : g_chk_b
      $error("irq_status_ctrl: source bit positions invalid");
   end
   if (STAT_ADDR == MASK_ADDR || STAT_ADDR == MODE_ADDR || MASK_ADDR == MODE_ADDR) begin : g_chk_a
      $error("irq_status_ctrl: register addresses must differ");
   end
   if ((STAT_ADDR >> ADDR_W) != 0 || (MASK_ADDR >> ADDR_W) != 0 || (MODE_ADDR >> ADDR_W) != 0) begin : g_chk_r
      $error("irq_status_ctrl: address does not fit ADDR_W");
   end

   logic [DATA_W-1:0] evt_vec;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] mask_q;
   logic [MODE_W-1:0] mode_q;
   logic              stat_rd;

   always_comb begin
      evt_vec             = '0;
      evt_vec[UNLOCK_BIT] = evt_unlock;
      evt_vec[OVFL_BIT]   = evt_ovfl;
   end

   irq_regbus #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .STAT_ADDR (STAT_ADDR),
      .MASK_ADDR (MASK_ADDR),
      .MODE_ADDR (MODE_ADDR),
      .REG_RDATA (REG_RDATA),
      .SRC_MAP   (SRC_MAP)
   ) regbus_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .stat_q    (stat_q),
      .bus_rdata (bus_rdata),
      .mask_q    (mask_q),
      .mode_q    (mode_q),
      .stat_rd   (stat_rd)
   );

   irq_sticky_bank #(
      .DATA_W  (DATA_W),
      .SRC_MAP (SRC_MAP)
   ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_vec (evt_vec),
      .mask_q  (mask_q),
      .rd_clr  (stat_rd),
      .stat_q  (stat_q)
   );

   irq_pin_drive #(
      .DATA_W (DATA_W)
   ) pin_i (
      .stat_q  (stat_q),
      .mask_q  (mask_q),
      .mode_q  (mode_q),
      .irq_pin (irq_pin),
      .irq_oe  (irq_oe)
   );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned STAT_ADDR  = 0,
   parameter int unsigned UNLOCK_BIT = 7,
   parameter int unsigned OVFL_BIT   = 1,
   parameter bit          REG_RDATA  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              evt_unlock,
   input logic              evt_ovfl,
   input logic [DATA_W-1:0] stat_q,
   input logic [DATA_W-1:0] mask_q,
   input logic [1:0]        mode_q,
   input logic              stat_rd,
   input logic              irq_pin,
   input logic              irq_oe
);

   localparam logic [DATA_W-1:0] SRC_MAP =
      (DATA_W'(1) << UNLOCK_BIT) | (DATA_W'(1) << OVFL_BIT);

   logic pend;
   logic any_evt;
   assign pend    = |(stat_q & mask_q);
   assign any_evt = evt_unlock || evt_ovfl;

   AST_EVT_SETS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_unlock && mask_q[UNLOCK_BIT]) |=> stat_q[UNLOCK_BIT]); // R2

   AST_EVT_SETS_OVFL: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ovfl && mask_q[OVFL_BIT]) |=> stat_q[OVFL_BIT]); // R2

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[UNLOCK_BIT] && mask_q[UNLOCK_BIT] && !stat_rd) |=> stat_q[UNLOCK_BIT]); // R2

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !any_evt) |=> (stat_q == '0)); // R3

   AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && evt_ovfl && mask_q[OVFL_BIT]) |=> stat_q[OVFL_BIT]); // R4

   AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_q[UNLOCK_BIT] |=> !stat_q[UNLOCK_BIT]); // R5

   AST_PIN_HIGH_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 || mode_q == 2'b11) |-> (irq_pin == pend && irq_oe)); // R7 R10

   AST_PIN_LOW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01) |-> (irq_pin == !pend && irq_oe)); // R8

   AST_PIN_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b10) |-> (!irq_pin && irq_oe == pend)); // R9

   if (REG_RDATA) begin : g_rd_chk
      AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(STAT_ADDR)) |=> ((bus_rdata & ~SRC_MAP) == '0)); // R2

      AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |=> $stable(bus_rdata)); // R13
   end

endmodule

bind irq_status_ctrl irq_status_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .STAT_ADDR  (STAT_ADDR),
   .UNLOCK_BIT (UNLOCK_BIT),
   .OVFL_BIT   (OVFL_BIT),
   .REG_RDATA  (REG_RDATA)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .evt_unlock (evt_unlock),
   .evt_ovfl   (evt_ovfl),
   .stat_q     (stat_q),
   .mask_q     (mask_q),
   .mode_q     (mode_q),
   .stat_rd    (stat_rd),
   .irq_pin    (irq_pin),
   .irq_oe     (irq_oe)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          evt_unlock = 1'b0;
   logic          evt_ovfl = 1'b0;
   logic          irq_pin;
   logic          irq_oe;

   int n_checks = 0;
   int n_errs = 0;
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_status_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .evt_unlock (evt_unlock),
      .evt_ovfl   (evt_ovfl),
      .irq_pin    (irq_pin),
      .irq_oe     (irq_oe)
   );

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   endtask

   // Driver: one-cycle read strobe, expected word pushed into the scoreboard.
   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pulse(input logic u, input logic o);
      @(negedge clk);
      evt_unlock = u;
      evt_ovfl   = o;
      @(negedge clk);
      evt_unlock = 1'b0;
      evt_ovfl   = 1'b0;
   endtask

   task automatic chk_pin(input logic ep, input logic eo, input string tag);
      n_checks++;
      if (irq_pin !== ep || irq_oe !== eo) begin
         n_errs++;
         $display("FAIL %s pin/oe actual %b/%b expected %b/%b", tag, irq_pin, irq_oe, ep, eo);
      end
   endtask

   // Monitor: compares registered read data one edge after the strobe.
   initial begin
      forever begin
         @(posedge clk);
         if (bus_rd) begin
            @(negedge clk);
            begin
               logic [DW-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               n_checks++;
               if (bus_rdata !== e) begin
                  n_errs++;
                  $display("FAIL %s rdata actual %h expected %h", t, bus_rdata, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_errs++;
      $display("FAIL watchdog expired actual hung expected done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_pin(1'b0, 1'b1, "R1 reset pin");
      rd(2'd0, 8'h00, "R1 status reset");
      rd(2'd1, 8'h82, "R1 mask reset");
      rd(2'd2, 8'h00, "R1 mode reset");

      pulse(1'b1, 1'b0);
      chk_pin(1'b1, 1'b1, "R7 pending high");
      rd(2'd0, 8'h80, "R2 unlock sticky");
      chk_pin(1'b0, 1'b1, "R7 cleared low");
      rd(2'd0, 8'h00, "R3 read clears");

      pulse(1'b0, 1'b1);
      pulse(1'b1, 1'b0);
      rd(2'd0, 8'h82, "R2 both sticky");
      rd(2'd0, 8'h00, "R3 clear both");

      // R4: event coincident with the read
      pulse(1'b0, 1'b1);
      @(negedge clk);
      evt_unlock = 1'b1;
      bus_addr = 2'd0;
      bus_rd = 1'b1;
      exp_q.push_back(8'h02);
      tag_q.push_back("R4 pre-clear value");
      @(negedge clk);
      bus_rd = 1'b0;
      evt_unlock = 1'b0;
      rd(2'd0, 8'h80, "R4 event survives clear");

      // R11: status writes ignored
      wr(2'd0, 8'hFF);
      rd(2'd0, 8'h00, "R11 write no set");
      pulse(1'b0, 1'b1);
      wr(2'd0, 8'h00);
      rd(2'd0, 8'h02, "R11 write no clear");

      // R6 / R5: mask register
      wr(2'd1, 8'hFF);
      rd(2'd1, 8'h82, "R6 mask writable bits");
      wr(2'd1, 8'h80);
      rd(2'd1, 8'h80, "R6 mask readback");
      pulse(1'b0, 1'b1);
      chk_pin(1'b0, 1'b1, "R5 masked no pending");
      rd(2'd0, 8'h00, "R5 masked event ignored");
      wr(2'd1, 8'h82);
      pulse(1'b1, 1'b0);
      wr(2'd1, 8'h02);
      chk_pin(1'b0, 1'b1, "R5 mask drops pending");
      wr(2'd1, 8'h82);
      rd(2'd0, 8'h00, "R5 stored bit discarded");

      // R8: active-low
      wr(2'd2, 8'h01);
      chk_pin(1'b1, 1'b1, "R8 idle high");
      pulse(1'b1, 1'b0);
      chk_pin(1'b0, 1'b1, "R8 pending low");
      rd(2'd0, 8'h80, "R8 clear");
      chk_pin(1'b1, 1'b1, "R8 idle after read");

      // R9: open drain
      wr(2'd2, 8'h02);
      chk_pin(1'b0, 1'b0, "R9 released");
      pulse(1'b0, 1'b1);
      chk_pin(1'b0, 1'b1, "R9 pulled low");
      rd(2'd0, 8'h02, "R9 clear");
      chk_pin(1'b0, 1'b0, "R9 released after read");

      // R10: reserved mode
      wr(2'd2, 8'h03);
      rd(2'd2, 8'h03, "R13 mode readback");
      chk_pin(1'b0, 1'b1, "R10 idle");
      pulse(1'b0, 1'b1);
      chk_pin(1'b1, 1'b1, "R10 pending high");
      rd(2'd0, 8'h02, "R10 clear");
      chk_pin(1'b0, 1'b1, "R10 cleared");
      wr(2'd2, 8'h00);

      // R12: held level
      @(negedge clk);
      evt_ovfl = 1'b1;
      @(negedge clk);
      rd(2'd0, 8'h02, "R12 held first read");
      rd(2'd0, 8'h02, "R12 held reappears");
      evt_ovfl = 1'b0;
      rd(2'd0, 8'h02, "R12 last set kept");
      rd(2'd0, 8'h00, "R12 gone after release");

      // R13: unmapped address and hold
      rd(2'd3, 8'h00, "R13 unmapped zero");
      rd(2'd1, 8'h82, "R13 mask before hold");
      repeat (3) @(negedge clk);
      n_checks++;
      if (bus_rdata !== 8'h82) begin
         n_errs++;
         $display("FAIL R13 rdata hold actual %h expected %h", bus_rdata, 8'h82);
      end

      repeat (2) @(negedge clk);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_errs++;
         $display("FAIL scoreboard residue actual %0d expected 0", exp_q.size());
      end
      summary();
   end

endmodule